// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read side of a serial configuration store. A configuring device supplies a clock. While the store is selected and its output enable is active, the store presents one stored bit per clock on a data line. The bit store is a synthesizable constant array, set by a parameter and organised as `NUM_WORDS` words of `WORD_W` bits. Read order is word 0 bit 0, then word 0 bit 1, and so on. The flat position `a*WORD_W+b` selects bit `INIT[a*WORD_W+b]`.

A single pin combines reset and output enable. A polarity input selects which level of that pin means reset, so the board needs no inverter. After the last bit has been read, the block stops driving its data line and pulls its active-low chip-enable-out low. A second store whose chip select is wired to that output then continues the stream with no gap. The tri-state data line is split into a value and an output-enable, so the float condition can be seen directly.

Top module: `cfgmem_reader`

## Requirements
- R1: After `rst_ni` is released, the read position is 0 and `ceo_no` is 1. With `ser_en_i=1`, `ce_ni=0` and reset/OE inactive, `data_oe_o=1` and `data_o=INIT[0]`.
- R2: Each rising edge with the read active advances the flat position by one. While driven, `data_o` equals `INIT[position]`, so bits leave in index order 0,1,2,...
- R3: `data_oe_o` is 1 only when all four of these hold: `ser_en_i=1`, `ce_ni=0`, reset/OE inactive, and the last bit not yet consumed. Otherwise the line floats.
- R4: An edge with reset/OE active returns the position to 0 and clears the finished state. This holds even when the same edge would otherwise count.
- R5: With `rst_pol_i=0`, `rst_oe_i=1` means reset and `rst_oe_i=0` enables output. With `rst_pol_i=1`, the meanings are swapped.
- R6: While `ce_ni=1`, the position does not change and `data_oe_o=0`. Reading resumes at the held position when `ce_ni` returns low.
- R7: The edge that consumes bit `DEPTH-1` sets the finished state. From the next cycle `data_oe_o=0`, and `ceo_no=0` while `ce_ni=0` and OE is active.
- R8: Once finished, `ceo_no` follows `ce_ni` while OE is active. It goes high as soon as reset/OE is active, and stays high until a full read completes again.
- R9: At the terminal position the counters hold and do not wrap; further clocks leave the output floating.
- R10: While `ser_en_i=0` (programming mode), the data line floats and the position holds, whatever the level of `ce_ni`.
- R11: When the `ceo_no` of one reader drives the `ce_ni` of a second reader, the second reader drives its bit 0 in the cycle after the first reader's last bit, then continues in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock from the configuring device |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ser_en_i | input | 1 | 1 = serial read mode, 0 = programming mode (read path idle) |
| ce_ni | input | 1 | Active-low chip select |
| rst_oe_i | input | 1 | Combined reset / output enable, meaning set by `rst_pol_i` |
| rst_pol_i | input | 1 | Polarity select for `rst_oe_i` |
| data_o | output | 1 | Serial data value (0 when not driven) |
| data_oe_o | output | 1 | Output driver enable for `data_o` |
| ceo_no | output | 1 | Active-low chip-enable-out to the next reader |

## Verification
The bench builds two readers with `WORD_W=4` and `NUM_WORDS=3`. That gives a 12-bit store whose word count is not a power of two. Each store therefore drains in a dozen clocks, so every bit of both stores can be compared against its parameter image. The word-wrap and terminal detection are exercised at a non-binary boundary. The chained pair makes the full cascade handoff reachable, together with the `ceo_no` follow-and-release behaviour and both reset polarities, all within a few hundred cycles.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 8,
  parameter logic [WORD_W*NUM_WORDS-1:0] INIT = '0,
  localparam int AW = cfgmem_pkg::cnt_w(NUM_WORDS),
  localparam int BW = cfgmem_pkg::cnt_w(WORD_W)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  output logic          bit_o
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words[w] = INIT[w*WORD_W +: WORD_W];
  end

  always_comb begin
    bit_o = 1'b0;
    if (int'(addr_i) < NUM_WORDS && int'(bit_i) < WORD_W)
      bit_o = words[addr_i][bit_i];
  end
endmodule

// File: rtl/cfgmem_counter.sv
module cfgmem_counter #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 8,
  localparam int AW    = cfgmem_pkg::cnt_w(NUM_WORDS),
  localparam int BW    = cfgmem_pkg::cnt_w(WORD_W),
  localparam int DEPTH = WORD_W * NUM_WORDS,
  localparam int PW    = cfgmem_pkg::cnt_w(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bit_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST_A = AW'(NUM_WORDS - 1);
  localparam logic [BW-1:0] LAST_B = BW'(WORD_W - 1);

  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;
  logic          done_q;
  logic          at_end;
  logic [PW-1:0] pos;

  assign at_end = (addr_q == LAST_A) && (bit_q == LAST_B);
  assign pos    = PW'(addr_q) * PW'(WORD_W) + PW'(bit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (en_i) begin
      if (at_end) begin
        done_q <= 1'b1;                 // hold at terminal, no wrap
      end else if (bit_q == LAST_B) begin
        bit_q  <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        bit_q  <= bit_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !at_end) |=> (pos == $past(pos) + 1'b1));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pos == '0 && !done_q));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(pos) && $stable(done_q)));
  p_finish_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && at_end) |=> done_q);
  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (pos == PW'(DEPTH - 1)));
endmodule

// File: rtl/cfgmem_outctl.sv
module cfgmem_outctl (
  input  logic ser_en_i,
  input  logic ce_ni,
  input  logic rst_oe_i,
  input  logic rst_pol_i,
  input  logic done_i,
  input  logic mem_bit_i,
  output logic clr_o,
  output logic cnt_en_o,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no
);
  logic reset_act;
  logic read_on;

  // pol=0: pin high resets; pol=1: pin low resets
  assign reset_act = rst_oe_i ^ rst_pol_i;
  assign read_on   = ser_en_i && !ce_ni && !reset_act;

  assign clr_o     = reset_act;
  assign cnt_en_o  = read_on && !done_i;
  assign data_oe_o = read_on && !done_i;
  assign data_o    = data_oe_o ? mem_bit_i : 1'b0;
  assign ceo_no    = !(done_i && !reset_act && !ce_ni);
endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 8,
  parameter logic [WORD_W*NUM_WORDS-1:0] INIT = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_en_i,
  input  logic ce_ni,
  input  logic rst_oe_i,
  input  logic rst_pol_i,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no
);
  localparam int AW = cfgmem_pkg::cnt_w(NUM_WORDS);
  localparam int BW = cfgmem_pkg::cnt_w(WORD_W);

  logic [AW-1:0] addr;
  logic [BW-1:0] bit_idx;
  logic          done;
  logic          clr;
  logic          cnt_en;
  logic          mem_bit;

  cfgmem_counter #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (cnt_en),
    .addr_o (addr),
    .bit_o  (bit_idx),
    .done_o (done)
  );

  cfgmem_array #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .INIT(INIT)) i_array (
    .addr_i (addr),
    .bit_i  (bit_idx),
    .bit_o  (mem_bit)
  );

  cfgmem_outctl i_outctl (
    .ser_en_i  (ser_en_i),
    .ce_ni     (ce_ni),
    .rst_oe_i  (rst_oe_i),
    .rst_pol_i (rst_pol_i),
    .done_i    (done),
    .mem_bit_i (mem_bit),
    .clr_o     (clr),
    .cnt_en_o  (cnt_en),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ceo_no    (ceo_no)
  );

  p_drive_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (ser_en_i && !ce_ni && (rst_oe_i == rst_pol_i) && !done));
  p_pol_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_oe_i != rst_pol_i) |-> (!data_oe_o && ceo_no));
  p_prog_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> !data_oe_o);
  p_ceo_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> (done && !ce_ni && !data_oe_o));
endmodule

// File: tb/test_cfgmem_reader.sv
module test_cfgmem_reader;
  localparam int WW = 4;
  localparam int NW = 3;
  localparam int DP = WW * NW;
  localparam logic [DP-1:0] IMG_A = 12'hA5C;
  localparam logic [DP-1:0] IMG_B = 12'h3E1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b1;
  logic ce_n = 1'b1;
  logic rst_oe = 1'b0;
  logic pol = 1'b0;
  logic d_a, oe_a, ceo_a, d_b, oe_b, ceo_b;
  int   checks = 0;
  int   errors = 0;
  bit   fin = 1'b0;

  always #5 clk = ~clk;

  cfgmem_reader #(.WORD_W(WW), .NUM_WORDS(NW), .INIT(IMG_A)) i_cfgmem_reader (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser_en), .ce_ni(ce_n),
    .rst_oe_i(rst_oe), .rst_pol_i(pol),
    .data_o(d_a), .data_oe_o(oe_a), .ceo_no(ceo_a)
  );

  cfgmem_reader #(.WORD_W(WW), .NUM_WORDS(NW), .INIT(IMG_B)) i_cfgmem_reader_b (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser_en), .ce_ni(ceo_a),
    .rst_oe_i(rst_oe), .rst_pol_i(pol),
    .data_o(d_b), .data_oe_o(oe_b), .ceo_no(ceo_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    #1_000_000;
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R1 oe with ce high", {31'd0, oe_a}, 0);
    chk("R1 ceo idle", {31'd0, ceo_a}, 1);
    ce_n = 1'b0; #1;
    chk("R1 oe enabled", {31'd0, oe_a}, 1);
    chk("R1 first bit", {31'd0, d_a}, {31'd0, IMG_A[0]});

    // full stream of A
    for (int k = 0; k < DP; k++) begin
      chk("R2 a stream bit", {31'd0, d_a}, {31'd0, IMG_A[k]});
      chk("R2 a stream oe", {31'd0, oe_a}, 1);
      chk("R11 b quiet", {31'd0, oe_b}, 0);
      tick(1);
    end
    chk("R7 a float after last", {31'd0, oe_a}, 0);
    chk("R7 a ceo low", {31'd0, ceo_a}, 0);
    // cascade into B
    for (int k = 0; k < DP; k++) begin
      chk("R11 b stream bit", {31'd0, d_b}, {31'd0, IMG_B[k]});
      chk("R11 b stream oe", {31'd0, oe_b}, 1);
      chk("R9 a still off", {31'd0, oe_a}, 0);
      tick(1);
    end
    chk("R7 b float after last", {31'd0, oe_b}, 0);
    chk("R7 b ceo low", {31'd0, ceo_b}, 0);
    tick(4);
    chk("R9 a holds off", {31'd0, oe_a}, 0);
    chk("R9 b holds off", {31'd0, oe_b}, 0);
    chk("R9 a ceo held", {31'd0, ceo_a}, 0);

    // ceo follows ce
    ce_n = 1'b1; #1;
    chk("R8 ceo follows ce high", {31'd0, ceo_a}, 1);
    tick(2);
    ce_n = 1'b0; #1;
    chk("R8 ceo follows ce low", {31'd0, ceo_a}, 0);
    chk("R9 no wrap on resume", {31'd0, oe_a}, 0);

    // reset via OE pin
    rst_oe = 1'b1; #1;
    chk("R8 ceo released by reset", {31'd0, ceo_a}, 1);
    chk("R3 float in reset", {31'd0, oe_a}, 0);
    tick(1);
    rst_oe = 1'b0; #1;
    chk("R4 restart oe", {31'd0, oe_a}, 1);
    chk("R4 restart bit0", {31'd0, d_a}, {31'd0, IMG_A[0]});
    chk("R8 ceo stays high", {31'd0, ceo_a}, 1);

    // chip select hold
    tick(5);
    chk("R2 pos5", {31'd0, d_a}, {31'd0, IMG_A[5]});
    ce_n = 1'b1; #1;
    chk("R6 float ce high", {31'd0, oe_a}, 0);
    tick(3);
    chk("R6 float held", {31'd0, oe_a}, 0);
    ce_n = 1'b0; #1;
    chk("R6 resume same pos", {31'd0, d_a}, {31'd0, IMG_A[5]});
    chk("R6 resume oe", {31'd0, oe_a}, 1);

    // reset beats count on same edge
    rst_oe = 1'b1;
    tick(1);
    rst_oe = 1'b0; #1;
    chk("R4 priority bit0", {31'd0, d_a}, {31'd0, IMG_A[0]});

    // inverted polarity
    pol = 1'b1; #1;
    chk("R5 pin low resets", {31'd0, oe_a}, 0);
    rst_oe = 1'b1; #1;
    chk("R5 pin high enables", {31'd0, oe_a}, 1);
    tick(3);
    chk("R5 counts pos3", {31'd0, d_a}, {31'd0, IMG_A[3]});
    rst_oe = 1'b0;
    tick(1);
    rst_oe = 1'b1; #1;
    chk("R5 inverted reset clears", {31'd0, d_a}, {31'd0, IMG_A[0]});
    tick(7);
    chk("R2 pos7 across word", {31'd0, d_a}, {31'd0, IMG_A[7]});

    // programming mode
    ser_en = 1'b0; #1;
    chk("R10 float in prog", {31'd0, oe_a}, 0);
    tick(3);
    chk("R10 float held", {31'd0, oe_a}, 0);
    ser_en = 1'b1; #1;
    chk("R10 pos held", {31'd0, d_a}, {31'd0, IMG_A[7]});
    chk("R10 oe back", {31'd0, oe_a}, 1);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule